// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds the write and erase protection state for the blocks of a flash array and answers, for every program or erase request, whether the addressed block may be touched. Protection is kept as a single unlocked window, an inclusive span of block addresses, or as one of two whole-array states: everything open, which is the state after reset, or everything locked. A sticky freeze flag can be raised so that the protection state can no longer change until the next hardware reset.

Control arrives as a one-cycle command strobe that carries a block address and a data word. Opening a window takes two commands: first the lower block, then the upper block, and the upper-block command applies the window. Requests arrive on a separate query strobe with a block address. One cycle later the block raises a permit, or it raises a locked-block interrupt pulse in place of the permit. A window whose bounds are not strictly ordered is rejected with an unsupported-command pulse. When the attached device has no locking support, all control commands are dropped.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset the whole array is open and the freeze flag is clear, so a query to any block is permitted.
- R2: A query with `qry_valid_i` high gives, on the next cycle, `qry_allow_o`=1 if the block is open, or `locked_irq_o`=1 for one cycle if the block is locked. The two are never high together, and both are low in any cycle that follows a cycle without a query.
- R3: Data word 0x10 stores the command's block as the pending lower bound, replacing any earlier pending bound. Data word 0x11, sent while a lower bound is pending and with a block strictly greater than that bound, replaces the protection state with a window. Exactly the blocks from the lower bound to the upper bound, both included, are then open. The pending bound is consumed.
- R4: Data word 0x21 locks every block, whatever block address is given, and discards any pending lower bound.
- R5: Data word 0x31 raises the freeze flag, whatever block address is given. After that, the words 0x10, 0x11, 0x21 and 0x31 change nothing and raise no pulse, until reset.
- R6: A 0x11 command whose block is less than or equal to the pending lower bound leaves the protection state unchanged. It consumes the pending bound and pulses `unsup_irq_o` for one cycle, on the cycle after the command.
- R7: A 0x11 command with no pending lower bound is ignored and raises no pulse.
- R8: While `lock_supported_i` is low, every command is ignored: the state does not change and no pulse is raised.
- R9: A query and a command in the same cycle: the query is judged against the protection state as it was before that command.
- R10: A data word other than 0x10, 0x11, 0x21 or 0x31 is ignored. All bits of the word are compared, so upper bits must be zero for a word to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_supported_i | input | 1 | Device accepts locking; when low, commands are dropped |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_blk_i | input | BLK_W | Block address carried by the command |
| cmd_data_i | input | DATA_W | Command data word |
| qry_valid_i | input | 1 | Program or erase request strobe |
| qry_blk_i | input | BLK_W | Block targeted by the request |
| qry_allow_o | output | 1 | Request permitted, one cycle after the query |
| locked_irq_o | output | 1 | Locked-block interrupt pulse, one cycle after a refused query |
| unsup_irq_o | output | 1 | Pulse for a rejected window (bounds not strictly ordered) |

## Verification
A protection check and a protection change can land in the same clock cycle. This case is provoked by driving a query and a command together: a lock-all over an open array, a window over a locked array, and a freeze followed by an attempted change. The cycle-accurate model in the bench judges the query against the state before the command, and it expects the command's effect to appear only on the query in the following cycle. Every output is compared against that model on every clock.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_WINDOW = 2'd1,
        LK_ALL    = 2'd2
    } lk_mode_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_LOWER   = 3'd1,
        OP_UPPER   = 3'd2,
        OP_LOCKALL = 3'd3,
        OP_FREEZE  = 3'd4
    } lk_op_e;

    localparam int unsigned CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_LOWER   = 8'h10;
    localparam logic [CODE_W-1:0] CODE_UPPER   = 8'h11;
    localparam logic [CODE_W-1:0] CODE_LOCKALL = 8'h21;
    localparam logic [CODE_W-1:0] CODE_FREEZE  = 8'h31;

endpackage

// File: rtl/lock_cmd_dec.sv
module lock_cmd_dec
    import flash_lock_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              valid_i,
    input  logic              supported_i,
    input  logic              frozen_i,
    input  logic [DATA_W-1:0] data_i,
    output lk_op_e            op_o
);
    localparam int unsigned PAD_W = DATA_W - CODE_W;

    logic accept;

    function automatic logic code_match(input logic [DATA_W-1:0] w,
                                        input logic [CODE_W-1:0] c);
        return w == {{PAD_W{1'b0}}, c};
    endfunction

    always_comb begin
        accept = valid_i && supported_i && !frozen_i;
        op_o   = OP_NONE;
        if (accept) begin
            if (code_match(data_i, CODE_LOWER))        op_o = OP_LOWER;
            else if (code_match(data_i, CODE_UPPER))   op_o = OP_UPPER;
            else if (code_match(data_i, CODE_LOCKALL)) op_o = OP_LOCKALL;
            else if (code_match(data_i, CODE_FREEZE))  op_o = OP_FREEZE;
        end
    end
endmodule

// File: rtl/lock_range_chk.sv
module lock_range_chk
    import flash_lock_pkg::*;
#(
    parameter int unsigned BLK_W = 12
) (
    input  lk_mode_e         mode_i,
    input  logic [BLK_W-1:0] lo_i,
    input  logic [BLK_W-1:0] hi_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             open_o
);
    logic in_window;

    always_comb begin
        in_window = (blk_i >= lo_i) && (blk_i <= hi_i);
        unique case (mode_i)
            LK_OPEN:   open_o = 1'b1;
            LK_WINDOW: open_o = in_window;
            default:   open_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flash_lock_pkg::*;
#(
    parameter int unsigned BLK_W  = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lock_supported_i,
    input  logic              cmd_valid_i,
    input  logic [BLK_W-1:0]  cmd_blk_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic              qry_valid_i,
    input  logic [BLK_W-1:0]  qry_blk_i,
    output logic              qry_allow_o,
    output logic              locked_irq_o,
    output logic              unsup_irq_o
);
    localparam int unsigned STATE_W = 2 + 2 * BLK_W;

    typedef struct packed {
        lk_mode_e         mode;
        logic [BLK_W-1:0] lo;
        logic [BLK_W-1:0] hi;
        logic             pend_vld;
        logic [BLK_W-1:0] pend_lo;
        logic             frozen;
        logic             allow;
        logic             deny;
        logic             unsup;
    } lk_state_t;

    lk_state_t s_d, s_q;
    lk_op_e    op;
    logic      blk_open;

    logic               frozen_w;
    logic [STATE_W-1:0] lock_state_w;

    lock_cmd_dec #(.DATA_W(DATA_W)) u_dec (
        .valid_i     (cmd_valid_i),
        .supported_i (lock_supported_i),
        .frozen_i    (s_q.frozen),
        .data_i      (cmd_data_i),
        .op_o        (op)
    );

    lock_range_chk #(.BLK_W(BLK_W)) u_rng (
        .mode_i (s_q.mode),
        .lo_i   (s_q.lo),
        .hi_i   (s_q.hi),
        .blk_i  (qry_blk_i),
        .open_o (blk_open)
    );

    always_comb begin
        s_d       = s_q;
        s_d.allow = qry_valid_i && blk_open;
        s_d.deny  = qry_valid_i && !blk_open;
        s_d.unsup = 1'b0;
        unique case (op)
            OP_LOWER: begin
                s_d.pend_vld = 1'b1;
                s_d.pend_lo  = cmd_blk_i;
            end
            OP_UPPER: begin
                if (s_q.pend_vld) begin
                    s_d.pend_vld = 1'b0;
                    if (s_q.pend_lo < cmd_blk_i) begin
                        s_d.mode = LK_WINDOW;
                        s_d.lo   = s_q.pend_lo;
                        s_d.hi   = cmd_blk_i;
                    end else begin
                        s_d.unsup = 1'b1;
                    end
                end
            end
            OP_LOCKALL: begin
                s_d.mode     = LK_ALL;
                s_d.pend_vld = 1'b0;
            end
            OP_FREEZE: s_d.frozen = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{mode: LK_OPEN, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign qry_allow_o  = s_q.allow;
    assign locked_irq_o = s_q.deny;
    assign unsup_irq_o  = s_q.unsup;

    assign frozen_w     = s_q.frozen;
    assign lock_state_w = {s_q.mode, s_q.lo, s_q.hi};
endmodule

// File: rtl/flash_lock_mgr_chk.sv
module flash_lock_mgr_chk #(
    parameter int unsigned STATE_W = 26
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               lock_supported_i,
    input logic               cmd_valid_i,
    input logic               qry_valid_i,
    input logic               qry_allow_o,
    input logic               locked_irq_o,
    input logic               unsup_irq_o,
    input logic               frozen,
    input logic [STATE_W-1:0] lock_state
);
    assert_allow_deny_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(qry_allow_o && locked_irq_o));

    assert_answer_needs_query_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !qry_valid_i |=> !(qry_allow_o || locked_irq_o));

    assert_query_answered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qry_valid_i |=> (qry_allow_o || locked_irq_o));

    assert_freeze_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frozen |=> frozen);

    assert_frozen_state_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frozen |=> ($stable(lock_state) && !unsup_irq_o));

    assert_unsupported_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_supported_i |=> ($stable(lock_state) && !unsup_irq_o && $stable(frozen)));

    assert_unsup_needs_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_valid_i && lock_supported_i) |=> !unsup_irq_o);
endmodule

bind flash_lock_mgr flash_lock_mgr_chk #(.STATE_W(STATE_W)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .lock_supported_i (lock_supported_i),
    .cmd_valid_i      (cmd_valid_i),
    .qry_valid_i      (qry_valid_i),
    .qry_allow_o      (qry_allow_o),
    .locked_irq_o     (locked_irq_o),
    .unsup_irq_o      (unsup_irq_o),
    .frozen           (frozen_w),
    .lock_state       (lock_state_w)
);

// File: tb/flash_lock_mgr_tb.sv
`timescale 1ns/1ps
module flash_lock_mgr_tb;
    localparam int BLK_W  = 12;
    localparam int DATA_W = 16;
    localparam int MAXB   = (1 << BLK_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sup = 1'b1;
    logic              cv = 1'b0;
    logic [BLK_W-1:0]  cblk = '0;
    logic [DATA_W-1:0] cdata = '0;
    logic              qv = 1'b0;
    logic [BLK_W-1:0]  qblk = '0;
    logic              allow, irq, unsup;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    int  m_mode;   // 0 open, 1 window, 2 all locked
    int  m_lo, m_hi, m_plo;
    bit  m_pend, m_frozen;
    bit  exp_allow, exp_irq, exp_unsup;

    always #2.5 clk = ~clk;

    flash_lock_mgr #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .lock_supported_i (sup),
        .cmd_valid_i      (cv),
        .cmd_blk_i        (cblk),
        .cmd_data_i       (cdata),
        .qry_valid_i      (qv),
        .qry_blk_i        (qblk),
        .qry_allow_o      (allow),
        .locked_irq_o     (irq),
        .unsup_irq_o      (unsup)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_lo = 0; m_hi = 0; m_plo = 0;
            m_pend = 0; m_frozen = 0;
            exp_allow = 0; exp_irq = 0; exp_unsup = 0;
        end else begin
            bit hit;
            hit = (m_mode == 0) || (m_mode == 1 && int'(qblk) >= m_lo && int'(qblk) <= m_hi);
            exp_allow = qv && hit;
            exp_irq   = qv && !hit;
            exp_unsup = 0;
            if (cv && sup && !m_frozen) begin
                case (cdata)
                    16'h0010: begin m_pend = 1; m_plo = int'(cblk); end
                    16'h0011: if (m_pend) begin
                        m_pend = 0;
                        if (m_plo < int'(cblk)) begin
                            m_mode = 1; m_lo = m_plo; m_hi = int'(cblk);
                        end else exp_unsup = 1;
                    end
                    16'h0021: begin m_mode = 2; m_pend = 0; end
                    16'h0031: m_frozen = 1;
                    default: ;
                endcase
            end
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        total++;
        if (allow !== exp_allow || irq !== exp_irq || unsup !== exp_unsup) begin
            bad++;
            $display("FAIL %s model compare: got allow=%0b irq=%0b unsup=%0b exp allow=%0b irq=%0b unsup=%0b",
                     cur_req, allow, irq, unsup, exp_allow, exp_irq, exp_unsup);
        end
    end

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0b exp %0b", tag, what, got, exp);
        end
    endtask

    task automatic cmd(input int blk, input int data);
        @(negedge clk);
        cv = 1'b1; cblk = BLK_W'(blk); cdata = DATA_W'(data);
        @(negedge clk);
        cv = 1'b0;
    endtask

    // query and directly check the permit / interrupt against a fixed value
    task automatic qchk(input int blk, input bit open, input string tag);
        @(negedge clk);
        qv = 1'b1; qblk = BLK_W'(blk);
        @(negedge clk);
        qv = 1'b0;
        check(tag, "permit", allow, open);
        check(tag, "locked irq", irq, !open);
    endtask

    // command that must (or must not) pulse the unsupported flag
    task automatic cmd_unsup(input int blk, input int data, input bit exp, input string tag);
        @(negedge clk);
        cv = 1'b1; cblk = BLK_W'(blk); cdata = DATA_W'(data);
        @(negedge clk);
        cv = 1'b0;
        check(tag, "unsup pulse", unsup, exp);
        @(negedge clk);
        check(tag, "unsup one cycle", unsup, 1'b0);
    endtask

    // command and query in the same cycle
    task automatic both(input int cb, input int data, input int qb, input bit open, input string tag);
        @(negedge clk);
        cv = 1'b1; cblk = BLK_W'(cb); cdata = DATA_W'(data);
        qv = 1'b1; qblk = BLK_W'(qb);
        @(negedge clk);
        cv = 1'b0; qv = 1'b0;
        check(tag, "same-cycle permit", allow, open);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset permit low", allow, 1'b0);
        check("R1", "reset irq low", irq, 1'b0);
        rst_n = 1'b1;

        cur_req = "R1";
        qchk(0, 1, "R1");
        qchk(MAXB, 1, "R1");
        qchk(1234, 1, "R1");

        cur_req = "R2";
        repeat (2) @(negedge clk);
        check("R2", "no query permit", allow, 1'b0);
        check("R2", "no query irq", irq, 1'b0);

        cur_req = "R3";
        cmd(10, 16'h10);
        qchk(500, 1, "R3");           // pending bound alone changes nothing
        cmd(20, 16'h11);
        qchk(9, 0, "R3");
        qchk(10, 1, "R3");
        qchk(15, 1, "R3");
        qchk(20, 1, "R3");
        qchk(21, 0, "R3");
        cmd(3, 16'h10);
        cmd(5, 16'h10);               // overwrite pending bound
        cmd(6, 16'h11);
        qchk(4, 0, "R3");
        qchk(5, 1, "R3");
        qchk(6, 1, "R3");
        qchk(15, 0, "R3");

        cur_req = "R4";
        cmd(77, 16'h21);
        qchk(5, 0, "R4");
        qchk(77, 0, "R4");
        cmd(100, 16'h10);
        cmd(50, 16'h21);              // discards pending bound
        cmd_unsup(200, 16'h11, 0, "R4");
        qchk(150, 0, "R4");

        cur_req = "R6";
        cmd(0, 16'h10);
        cmd(MAXB, 16'h11);
        qchk(MAXB, 1, "R6");
        cmd(30, 16'h10);
        cmd_unsup(30, 16'h11, 1, "R6");
        cmd(40, 16'h10);
        cmd_unsup(35, 16'h11, 1, "R6");
        qchk(2000, 1, "R6");          // state untouched
        cmd_unsup(45, 16'h11, 0, "R6"); // bound was consumed

        cur_req = "R7";
        cmd_unsup(60, 16'h11, 0, "R7");
        qchk(0, 1, "R7");

        cur_req = "R10";
        cmd(5, 16'h12);
        cmd(5, 16'h0000);
        cmd(5, 16'h0121);             // upper bits set: no match
        qchk(9, 1, "R10");

        cur_req = "R8";
        sup = 1'b0;
        cmd(1, 16'h21);
        cmd(8, 16'h10);
        sup = 1'b1;
        cmd_unsup(9, 16'h11, 0, "R8");
        qchk(3000, 1, "R8");

        cur_req = "R9";
        both(0, 16'h21, 400, 1, "R9");
        qchk(400, 0, "R9");
        cmd(100, 16'h10);
        both(200, 16'h11, 150, 0, "R9");
        qchk(150, 1, "R9");

        cur_req = "R5";
        both(0, 16'h31, 150, 1, "R5");
        cmd(0, 16'h21);
        qchk(150, 1, "R5");
        cmd(1, 16'h10);
        cmd(2, 16'h11);
        qchk(100, 1, "R5");
        qchk(1, 0, "R5");
        cmd(10, 16'h10);
        cmd_unsup(5, 16'h11, 0, "R5");

        cur_req = "R1";
        do_reset();
        qchk(1, 1, "R1");
        cmd(0, 16'h21);
        qchk(1, 0, "R1");             // freeze cleared by reset

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule